// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block is a slave on a two-wire serial bus (I2C-style) that only accepts writes. It samples SCL and SDA with the system clock and finds start and stop conditions. A transfer carries a device address byte, then a subaddress byte, then one or more data bytes. The slave acknowledges each byte by pulling SDA low, and the data bytes load a small bank of 8-bit control registers.

The top bit of the subaddress picks how data bytes are placed. When it is clear, every data byte overwrites the same register. When it is set, the target advances by one after each byte. In that auto-advance mode, subaddresses with bit 2 set are a hole: their bytes are acknowledged but dropped. Register contents are presented in parallel, and each register has a one-cycle write strobe. One bit of the device address comes from a strap pin, so two slaves can share a bus.

Top module: `i2c_wr_regs`

## Requirements
- R1: SCL and SDA pass through two-flop synchronizers. SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A start at any point, including a repeated start part-way through a byte, begins a new address byte. After a stop, clocked bytes change nothing until a new start.
- R2: The address byte is sent MSB first as 1,0,0,0,0,0,A,0, where A equals `addr_strap` and the final 0 means write. Any other byte, including one whose last bit is 1 (read), gets no acknowledge, and nothing is written until the next start.
- R3: The slave acknowledges a matching address byte, the subaddress byte and every data byte. It raises `sda_pd_o` at the SCL falling edge that ends the eighth bit and drops it at the next SCL falling edge, both as seen through the synchronizers. At no other time is `sda_pd_o` high.
- R4: If subaddress bit 7 is 0, every data byte of the transfer goes to register number subaddress[1:0].
- R5: If subaddress bit 7 is 1, the first data byte goes to register subaddress[1:0]. After each data byte, the low five subaddress bits count up by one and wrap from 31 to 0, while bits 7..5 stay as they were.
- R6: In auto-advance mode, a data byte whose current subaddress has bit 2 set changes no register and raises no strobe. The byte is still acknowledged, and the subaddress still advances.
- R7: Each accepted data byte raises exactly one bit of `wr_stb_o` (bit i for register i) for one cycle. Register i changes on that same cycle, and registers change on no other cycle.
- R8: Reset leaves every register at 0x00, with `sda_pd_o` and `wr_stb_o` low. Register i appears on `regs_o[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| addr_strap | input | 1 | Selectable device address bit |
| sda_pd_o | output | 1 | Active-high enable of the SDA pull-down |
| regs_o | output | 8*NREG | Register contents, register i at bits 8i+7..8i |
| wr_stb_o | output | NREG | One-cycle write strobe per register |

## Verification
The assertions check the per-cycle rules on every clock. The strobe is one-hot and lasts a single cycle. A register changes only together with a strobe. An acknowledge starts only after eight received bits. The slave stays silent while idle. No strobe follows a byte that falls in the ignored hole. The bench scenarios are needed for the rest. They show which register each byte lands in under both subaddress modes, the wrap of the five-bit counter, the rejection of a wrong address and of a read request, a repeated start inside a byte, and bytes clocked after a stop. A behavioural model is compared against all outputs on every clock to confirm those results.

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs #(
  parameter int NREG = 4,
  parameter logic [5:0] DEV_HI = 6'b100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  output logic              sda_pd_o,
  output logic [8*NREG-1:0] regs_o,
  output logic [NREG-1:0]   wr_stb_o
);
  localparam int IW = $clog2(NREG);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_SUB, S_DATA} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] sh, sub;
  logic [7:0] regs [NREG];

  wire scl_c = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_c = sda_q[1];
  wire sda_p = sda_q[2];

  wire start_ev = scl_c & scl_p & sda_p & ~sda_c;
  wire stop_ev  = scl_c & scl_p & ~sda_p & sda_c;
  wire rise     = scl_c & ~scl_p;
  wire fall     = ~scl_c & scl_p;
  wire addr_ok  = sh == {DEV_HI, addr_strap, 1'b0};
  wire skip     = sub[7] & sub[2];
  wire [IW-1:0] idx = sub[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bcnt     <= '0;
      sh       <= '0;
      sub      <= '0;
      sda_pd_o <= 1'b0;
      wr_stb_o <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      wr_stb_o <= '0;
      if (start_ev) begin
        st       <= S_ADDR;
        bcnt     <= '0;
        sda_pd_o <= 1'b0;
      end else if (stop_ev) begin
        st       <= S_IDLE;
        bcnt     <= '0;
        sda_pd_o <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise && bcnt < 4'd8) begin
          sh   <= {sh[6:0], sda_c};
          bcnt <= bcnt + 4'd1;
        end else if (fall && bcnt == 4'd8) begin
          case (st)
            S_ADDR: begin
              if (addr_ok) begin
                sda_pd_o <= 1'b1;
                bcnt     <= 4'd9;
              end else begin
                st <= S_IDLE;
              end
            end
            S_SUB: begin
              sub      <= sh;
              sda_pd_o <= 1'b1;
              bcnt     <= 4'd9;
            end
            default: begin
              sda_pd_o <= 1'b1;
              bcnt     <= 4'd9;
              if (!skip) begin
                regs[idx]     <= sh;
                wr_stb_o[idx] <= 1'b1;
              end
              if (sub[7]) sub[4:0] <= sub[4:0] + 5'd1;
            end
          endcase
        end else if (fall && bcnt == 4'd9) begin
          sda_pd_o <= 1'b0;
          bcnt     <= '0;
          st       <= (st == S_ADDR) ? S_SUB : S_DATA;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[8*g +: 8] = regs[g];
  end

  p_stb_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb_o));
  p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o != '0) |=> (wr_stb_o == '0));
  p_reg_needs_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> (wr_stb_o != '0));
  p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> ($past(bcnt) == 4'd8));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!sda_pd_o && wr_stb_o == '0));
  p_hole_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_DATA && $past(sub[7] & sub[2])) |-> (wr_stb_o == '0));
endmodule

// File: tb/i2c_wr_regs_test.sv
module i2c_wr_regs_test;
  localparam int CLK_P = 10;
  localparam int NREG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b1;
  logic sda_pd;
  logic [8*NREG-1:0] regs;
  logic [NREG-1:0] stb;
  wire sda_bus = m_sda & ~sda_pd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_wr_regs #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_strap(strap), .sda_pd_o(sda_pd), .regs_o(regs), .wr_stb_o(stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int h_scl[3], h_sda[3];
  int m_st, m_nb, m_byte, m_sub, m_ack, m_stb;
  int m_reg[NREG];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin h_scl[i] = 1; h_sda[i] = 1; end
      m_st = 0; m_nb = 0; m_byte = 0; m_sub = 0; m_ack = 0; m_stb = 0;
      for (int i = 0; i < NREG; i++) m_reg[i] = 0;
    end else begin
      int c_scl, p_scl, c_sda, p_sda;
      c_scl = h_scl[1]; p_scl = h_scl[2]; c_sda = h_sda[1]; p_sda = h_sda[2];
      m_stb = 0;
      if (c_scl && p_scl && p_sda && !c_sda) begin
        m_st = 1; m_nb = 0; m_ack = 0;
      end else if (c_scl && p_scl && !p_sda && c_sda) begin
        m_st = 0; m_nb = 0; m_ack = 0;
      end else if (m_st != 0 && c_scl && !p_scl) begin
        if (m_nb < 8) begin m_byte = ((m_byte << 1) | c_sda) & 255; m_nb++; end
      end else if (m_st != 0 && !c_scl && p_scl) begin
        if (m_nb == 8) begin
          if (m_st == 1) begin
            if (m_byte == (8'h80 | (int'(strap) << 1))) begin m_ack = 1; m_nb = 9; end
            else m_st = 0;
          end else if (m_st == 2) begin
            m_sub = m_byte; m_ack = 1; m_nb = 9;
          end else begin
            m_ack = 1; m_nb = 9;
            if (!((m_sub & 8'h80) != 0 && (m_sub & 4) != 0)) begin
              m_reg[m_sub % NREG] = m_byte;
              m_stb = 1 << (m_sub % NREG);
            end
            if ((m_sub & 8'h80) != 0) m_sub = (m_sub & 8'hE0) | ((m_sub + 1) & 8'h1F);
          end
        end else if (m_nb == 9) begin
          m_ack = 0; m_nb = 0;
          m_st = (m_st == 1) ? 2 : 3;
        end
      end
      h_scl[2] = h_scl[1]; h_scl[1] = h_scl[0]; h_scl[0] = m_scl;
      h_sda[2] = h_sda[1]; h_sda[1] = h_sda[0]; h_sda[0] = sda_bus;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NREG; i++)
        chk(regs[8*i +: 8] == m_reg[i][7:0], "R7 register contents", int'(regs[8*i +: 8]), m_reg[i]);
      chk(int'(stb) == m_stb, "R7 write strobe", int'(stb), m_stb);
      chk(int'(sda_pd) == m_ack, "R3 acknowledge pull-down", int'(sda_pd), m_ack);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(4); m_scl = 1'b1; wt(8);
    m_sda = 1'b0; wt(8); m_scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(4); m_scl = 1'b1; wt(8); m_sda = 1'b1; wt(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wt(4); m_scl = 1'b1; wt(8); m_scl = 1'b0; wt(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; wt(4); m_scl = 1'b1; wt(4);
    ack = !sda_bus; wt(4); m_scl = 1'b0; wt(4);
  endtask

  task automatic chk_reg(input int i, input int exp, input string req);
    chk(regs[8*i +: 8] == exp[7:0], req, int'(regs[8*i +: 8]), exp);
  endtask

  initial begin
    bit a;
    wt(5);
    chk(regs == '0, "R8 reset registers", int'(regs), 0);
    chk(sda_pd == 1'b0 && stb == '0, "R8 reset outputs", int'({sda_pd, stb}), 0);
    rst_n = 1'b1; wt(4);

    // R4: single-register mode, strap = 1 -> address 0x82
    bus_start();
    send_byte(8'h82, a); chk(a, "R2 address ack", a, 1);
    send_byte(8'h02, a); chk(a, "R3 subaddress ack", a, 1);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk(a, "R3 data ack", a, 1);
    bus_stop();
    chk_reg(2, 8'h33, "R4 same register overwritten");
    chk_reg(3, 8'h00, "R4 neighbour untouched");

    // R5 and R6: auto-advance through the hole
    bus_start();
    send_byte(8'h82, a); send_byte(8'h81, a);
    send_byte(8'hA1, a); send_byte(8'hA2, a); send_byte(8'hA3, a);
    send_byte(8'hA4, a); chk(a, "R6 hole byte still acked", a, 1);
    bus_stop();
    chk_reg(1, 8'hA1, "R5 first byte"); chk_reg(2, 8'hA2, "R5 second byte");
    chk_reg(3, 8'hA3, "R5 third byte"); chk_reg(0, 8'h00, "R6 hole byte dropped");

    // R5: wrap of low five bits, 0x9E and 0x9F ignored, then 0x80
    bus_start();
    send_byte(8'h82, a); send_byte(8'h9E, a);
    send_byte(8'hB0, a); send_byte(8'hB1, a); send_byte(8'hB2, a);
    bus_stop();
    chk_reg(0, 8'hB2, "R5 counter wraps to 0");
    chk_reg(2, 8'hA2, "R6 hole bytes dropped");

    // R2: wrong strap bit and read direction
    bus_start();
    send_byte(8'h80, a); chk(!a, "R2 wrong address no ack", a, 0);
    send_byte(8'h00, a); send_byte(8'hEE, a);
    bus_stop();
    chk_reg(0, 8'hB2, "R2 no write after mismatch");
    bus_start();
    send_byte(8'h83, a); chk(!a, "R2 read request no ack", a, 0);
    bus_stop();
    strap = 1'b0;
    bus_start();
    send_byte(8'h80, a); chk(a, "R2 strap 0 address ack", a, 1);
    send_byte(8'h01, a); send_byte(8'h5C, a);
    bus_stop();
    chk_reg(1, 8'h5C, "R2 write with strap 0");

    // R1: repeated start inside a byte, then bytes after a stop
    bus_start();
    send_byte(8'h80, a); send_byte(8'h03, a);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(8'h80, a); chk(a, "R1 repeated start readdressed", a, 1);
    send_byte(8'h03, a); send_byte(8'h5A, a);
    bus_stop();
    chk_reg(3, 8'h5A, "R1 write after repeated start");
    send_byte(8'h80, a); chk(!a, "R1 no ack after stop", a, 0);
    send_byte(8'h03, a); send_byte(8'h77, a);
    m_sda = 1'b1; m_scl = 1'b1; wt(20);
    chk_reg(3, 8'h5A, "R1 bytes after stop ignored");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule